// File: doc/BRIEF.md
# Warp memory address coalescer

This block takes one memory instruction issued for a 32-lane thread group and reduces the lane addresses to the fewest memory transactions. Each lane supplies a 4-byte-aligned byte address and an enable bit. A mode pair (store, cache bypass) picks the transaction size. Cached loads use aligned 128-byte lines. Bypassing loads and stores use aligned 32-byte segments, and these also tell the first-level cache to drop any copy it holds.

An instruction is accepted over a valid/ready pair. The block then emits one request per distinct unit on a second valid/ready pair, lowest address first, at most one per cycle. Each request carries the unit's base address and a byte mask of the bytes the enabled lanes touch. When the last request has been taken, a one-cycle completion pulse presents two totals: the bytes the lanes asked for and the bytes moved on the bus. Their ratio is the bus utilization of the instruction.

Top module: `warp_coalescer`

## Requirements
- R1: With in_store=0 and in_bypass=0, one request is produced per distinct 128-byte-aligned line touched by an enabled lane. req_base is the line address (low 7 bits zero) and req_inval=0.
- R2: With in_store=1 or in_bypass=1, one request is produced per distinct 32-byte-aligned segment. req_base has its low 5 bits zero, req_inval=1, and req_byte_en bits 127:32 are zero.
- R3: Bit i of req_byte_en is 1 exactly when some enabled lane's 4-byte word covers byte req_base+i. Lanes naming the same word share one request and set the same four bits.
- R4: Lanes whose in_mask bit is 0 have no effect on requests or totals. An all-zero mask produces no request, and done pulses in the cycle after acceptance with both totals zero.
- R5: Requests leave in strictly ascending req_base order with no idle cycle between them. While req_valid=1 and req_ready=0, req_base and req_byte_en hold.
- R6: in_ready is 0 from the cycle after an instruction is accepted until done pulses.
- R7: done is high for the one cycle after the handshake of the request with req_last=1. bytes_needed is then the sum of set req_byte_en bits over the instruction, and bytes_moved is the request count times the unit size (128 or 32).
- R8: After reset, req_valid=0, done=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken when in_valid is high |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits i*ADDR_W upward |
| in_mask | input | LANES | Lane enables |
| in_store | input | 1 | 1 = store |
| in_bypass | input | 1 | 1 = load that skips the first-level cache |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request taken |
| req_base | output | ADDR_W | Aligned unit address |
| req_byte_en | output | LINE_BYTES | Bytes wanted within the unit |
| req_inval | output | 1 | Cache copy must be dropped (segment mode) |
| req_last | output | 1 | Final request of the instruction |
| done | output | 1 | One-cycle completion pulse |
| bytes_needed | output | CNT_W | Distinct bytes requested by lanes |
| bytes_moved | output | CNT_W | Bytes carried by all requests |

## Verification
The properties assume that lane addresses are multiples of four. They also assume that the instruction fields are only read in the cycle in_valid and in_ready are both high. The bench builds every address as a base plus four times an index, and drives the fields only while in_valid is high. It withholds req_ready on a pseudo-random pattern, so the hold and ordering rules are exercised across stalls as well as full-rate draining.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int unsigned WORD_BYTES = 4;

  // log2 of the transaction unit selected by the mode
  function automatic int unsigned unit_lg(input logic fine, input int unsigned line_b,
                                          input int unsigned seg_b);
    return fine ? $clog2(seg_b) : $clog2(line_b);
  endfunction
endpackage

// File: rtl/wc_lane_units.sv
module wc_lane_units #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32
) (
  input  logic [LANES*ADDR_W-1:0]            addr,
  input  logic                               fine,
  output logic [LANES*ADDR_W-1:0]            units,
  output logic [LANES*$clog2(LINE_BYTES)-1:0] offs
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] a;
    logic [OFF_W-1:0]  o;
    assign a = addr[i*ADDR_W +: ADDR_W];
    always_comb begin
      o = a[OFF_W-1:0];
      if (fine) o = o & OFF_W'(SEG_BYTES - 1);
      o[1:0] = 2'b00;
    end
    assign units[i*ADDR_W +: ADDR_W] =
      a >> wc_pkg::unit_lg(fine, LINE_BYTES, SEG_BYTES);
    assign offs[i*OFF_W +: OFF_W] = o;
  end
endmodule

// File: rtl/wc_unit_min.sv
module wc_unit_min #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic [LANES*ADDR_W-1:0] units,
  input  logic [LANES-1:0]        pending,
  output logic [ADDR_W-1:0]       min_unit
);
  always_comb begin
    logic found;
    found    = 1'b0;
    min_unit = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pending[i] && (!found || units[i*ADDR_W +: ADDR_W] < min_unit)) begin
        min_unit = units[i*ADDR_W +: ADDR_W];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wc_gather.sv
module wc_gather #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic [LANES*ADDR_W-1:0]             units,
  input  logic [LANES*$clog2(LINE_BYTES)-1:0] offs,
  input  logic [LANES-1:0]                    pending,
  input  logic [ADDR_W-1:0]                   min_unit,
  output logic [LANES-1:0]                    hit,
  output logic [LINE_BYTES-1:0]               byte_en
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  for (genvar i = 0; i < LANES; i++) begin : g_hit
    assign hit[i] = pending[i] && (units[i*ADDR_W +: ADDR_W] == min_unit);
  end

  always_comb begin
    byte_en = '0;
    for (int i = 0; i < LANES; i++)
      if (hit[i]) byte_en[offs[i*OFF_W +: OFF_W] +: wc_pkg::WORD_BYTES] = '1;
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32,
  parameter int CNT_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*ADDR_W-1:0]   in_addr,
  input  logic [LANES-1:0]          in_mask,
  input  logic                      in_store,
  input  logic                      in_bypass,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_base,
  output logic [LINE_BYTES-1:0]     req_byte_en,
  output logic                      req_inval,
  output logic                      req_last,
  output logic                      done,
  output logic [CNT_W-1:0]          bytes_needed,
  output logic [CNT_W-1:0]          bytes_moved
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic                      busy_q, fine_q, done_q;
  logic [LANES*ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]          pending_q;
  logic [CNT_W-1:0]          needed_q, moved_q;

  // named internal events
  logic                      accept_w, fire_w;
  logic [LANES*ADDR_W-1:0]   units_w;
  logic [LANES*OFF_W-1:0]    offs_w;
  logic [ADDR_W-1:0]         min_unit_w;
  logic [LANES-1:0]          hit_w, remain_w;
  logic [CNT_W-1:0]          be_count_w, unit_size_w;

  wc_lane_units #(.LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
                  .SEG_BYTES(SEG_BYTES)) u_units (
    .addr(addr_q), .fine(fine_q), .units(units_w), .offs(offs_w));

  wc_unit_min #(.LANES(LANES), .ADDR_W(ADDR_W)) u_min (
    .units(units_w), .pending(pending_q), .min_unit(min_unit_w));

  wc_gather #(.LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_gather (
    .units(units_w), .offs(offs_w), .pending(pending_q), .min_unit(min_unit_w),
    .hit(hit_w), .byte_en(req_byte_en));

  assign in_ready    = !busy_q;
  assign accept_w    = in_valid && in_ready;
  assign req_valid   = busy_q;
  assign fire_w      = req_valid && req_ready;
  assign remain_w    = pending_q & ~hit_w;
  assign req_last    = (remain_w == '0);
  assign req_inval   = fine_q;
  assign req_base    = min_unit_w << wc_pkg::unit_lg(fine_q, LINE_BYTES, SEG_BYTES);
  assign be_count_w  = CNT_W'($countones(req_byte_en));
  assign unit_size_w = fine_q ? CNT_W'(SEG_BYTES) : CNT_W'(LINE_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      fine_q    <= 1'b0;
      done_q    <= 1'b0;
      addr_q    <= '0;
      pending_q <= '0;
      needed_q  <= '0;
      moved_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        addr_q    <= in_addr;
        pending_q <= in_mask;
        fine_q    <= in_store | in_bypass;
        needed_q  <= '0;
        moved_q   <= '0;
        busy_q    <= |in_mask;
        done_q    <= ~|in_mask;
      end else if (fire_w) begin
        pending_q <= remain_w;
        needed_q  <= needed_q + be_count_w;
        moved_q   <= moved_q + unit_size_w;
        if (req_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done         = done_q;
  assign bytes_needed = needed_q;
  assign bytes_moved  = moved_q;
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [ADDR_W-1:0]     req_base,
  input logic [LINE_BYTES-1:0] req_byte_en,
  input logic                  req_inval,
  input logic                  req_last,
  input logic                  done
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_base <= '0;
    end else if (req_valid && req_ready) begin
      have_prev <= !req_last;
      prev_base <= req_base;
    end
  end

  a_r1_line_align: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_inval |-> (req_base & ADDR_W'(LINE_BYTES - 1)) == '0);

  a_r2_seg_shape: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_inval |-> (req_base & ADDR_W'(SEG_BYTES - 1)) == '0
                               && (req_byte_en >> SEG_BYTES) == '0);

  a_r3_some_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_byte_en != '0);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_base) && $stable(req_byte_en));

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && have_prev |-> req_base > prev_base);

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !in_ready);

  a_r7_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_last |=> done);
endmodule

bind warp_coalescer wc_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
                                 .SEG_BYTES(SEG_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .req_valid(req_valid),
  .req_ready(req_ready), .req_base(req_base), .req_byte_en(req_byte_en),
  .req_inval(req_inval), .req_last(req_last), .done(done));

// File: tb/warp_coalescer_test.sv
`timescale 1ns/1ps
module warp_coalescer_test;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int LB    = 128;
  localparam int CW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_valid = 1'b0, in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0]  in_mask = '0;
  logic              in_store = 1'b0, in_bypass = 1'b0;
  logic              req_valid, req_ready = 1'b1, req_inval, req_last, done;
  logic [AW-1:0]     req_base;
  logic [LB-1:0]     req_byte_en;
  logic [CW-1:0]     bytes_needed, bytes_moved;

  warp_coalescer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .in_store(in_store), .in_bypass(in_bypass),
    .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
    .req_byte_en(req_byte_en), .req_inval(req_inval), .req_last(req_last),
    .done(done), .bytes_needed(bytes_needed), .bytes_moved(bytes_moved));

  typedef struct {
    logic [AW-1:0] base;
    logic [LB-1:0] be;
    logic          inv;
    logic          last;
  } exp_t;

  exp_t        exp_q[$];
  logic [CW-1:0] need_q[$];
  logic [CW-1:0] move_q[$];
  logic [AW-1:0] stim_addr [LANES];

  int   errors = 0, checks = 0, done_cnt = 0;
  bit   outstanding = 0, stall_en = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [LB-1:0] act, input logic [LB-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // driver: builds the expectation, then issues the instruction
  task automatic send(input logic [LANES-1:0] m, input logic st, input logic byp);
    logic [LB-1:0] units [longint unsigned];
    int unsigned   sz = (st || byp) ? 32 : 128;
    int unsigned   n = 0, need = 0, k = 0, target;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        longint unsigned u;
        int unsigned off;
        u   = longint'(stim_addr[i]) / sz;
        off = stim_addr[i] % sz;
        if (!units.exists(u)) units[u] = '0;
        units[u][off +: 4] = 4'hF;
      end
    end
    n = units.num();
    foreach (units[u]) begin
      exp_t e;
      e.base = AW'(u * sz);
      e.be   = units[u];
      e.inv  = st || byp;
      k++;
      e.last = (k == n);
      need  += $countones(units[u]);
      exp_q.push_back(e);
    end
    need_q.push_back(CW'(need));
    move_q.push_back(CW'(n * sz));
    target = done_cnt + 1;
    @(posedge clk); #1;
    while (!in_ready) begin @(posedge clk); #1; end
    in_valid  = 1'b1;
    in_mask   = m;
    in_store  = st;
    in_bypass = byp;
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = stim_addr[i];
    @(posedge clk); #1;
    in_valid    = 1'b0;
    outstanding = 1;
    while (done_cnt < target) @(negedge clk);
  endtask

  // ready pattern
  initial begin
    logic [15:0] lf = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      req_ready = stall_en ? lf[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  bit            prev_stall = 0, want_next = 0;
  logic [AW-1:0] prev_base;
  logic [LB-1:0] prev_be;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(req_valid && req_base == prev_base && req_byte_en == prev_be,
              "R5", "stalled request changed", LB'(req_base), LB'(prev_base));
      if (want_next)
        check(req_valid, "R5", "gap between requests", LB'(req_valid), 1);
      if (outstanding && !done)
        check(!in_ready, "R6", "in_ready while busy", LB'(in_ready), 0);
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R4", "unexpected request", LB'(req_base), 0);
        end else begin
          exp_t e;
          string tg;
          e  = exp_q.pop_front();
          tg = e.inv ? "R2" : "R1";
          check(req_base == e.base, tg, "base", LB'(req_base), LB'(e.base));
          check(req_byte_en == e.be, "R3", "byte enables", req_byte_en, e.be);
          check(req_inval == e.inv, tg, "inval", LB'(req_inval), LB'(e.inv));
          check(req_last == e.last, "R7", "last flag", LB'(req_last), LB'(e.last));
        end
      end
      if (done) begin
        logic [CW-1:0] en, em;
        en = need_q.size() ? need_q.pop_front() : '0;
        em = move_q.size() ? move_q.pop_front() : '0;
        check(bytes_needed == en, "R7", "bytes_needed", LB'(bytes_needed), LB'(en));
        check(bytes_moved == em, "R7", "bytes_moved", LB'(bytes_moved), LB'(em));
        check(exp_q.size() == 0, "R7", "done before all requests",
              LB'(exp_q.size()), 0);
        outstanding = 0;
        done_cnt++;
      end
      prev_stall = req_valid && !req_ready;
      prev_base  = req_base;
      prev_be    = req_byte_en;
      want_next  = req_valid && req_ready && !req_last;
    end
  end

  task automatic fill_linear(input logic [AW-1:0] base);
    for (int i = 0; i < LANES; i++) stim_addr[i] = base + AW'(4 * i);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] lf = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!req_valid && !done && in_ready, "R8", "reset state",
          LB'({req_valid, done, in_ready}), 1);

    // R1: aligned consecutive, cached -> one line
    fill_linear(32'h1000);
    send('1, 0, 0);
    // R1: permuted lane order
    for (int i = 0; i < LANES; i++) stim_addr[i] = 32'h2000 + AW'(4 * ((i * 7) % 32));
    send('1, 0, 0);
    // R2: aligned bypass load -> four segments
    fill_linear(32'h1000);
    send('1, 0, 1);
    // R1: misaligned cached -> two lines
    fill_linear(32'h1040);
    send('1, 0, 0);
    // R2: misaligned bypass -> five segments
    fill_linear(32'h1044);
    send('1, 0, 1);
    // R2: scattered store
    for (int i = 0; i < LANES; i++) stim_addr[i] = 32'h8000 + AW'(i * 260);
    send('1, 1, 0);
    // R4: partial mask, disabled lanes point elsewhere
    fill_linear(32'h3000);
    for (int i = 16; i < LANES; i++) stim_addr[i] = 32'h9000_0000;
    send(32'h0000_FFFF, 0, 0);
    // R4: empty mask
    send('0, 0, 0);
    // R3: all lanes on one word
    for (int i = 0; i < LANES; i++) stim_addr[i] = 32'h4444;
    send('1, 1, 0);
    // R1/R2: top of address space
    fill_linear(32'hFFFF_FF80);
    send('1, 0, 0);
    send('1, 0, 1);
    // R5: stalls on the request side
    stall_en = 1;
    fill_linear(32'h5044);
    send('1, 1, 0);
    for (int t = 0; t < 12; t++) begin
      logic [LANES-1:0] m;
      for (int i = 0; i < LANES; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        stim_addr[i] = 32'h0001_0000 + AW'(t * 512) + AW'(4 * (lf % 96));
      end
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      m  = lf ^ {lf[15:0], lf[31:16]};
      send(m, lf[3] & lf[5], lf[7]);
    end
    stall_en = 0;
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule